// File: doc/BRIEF.md
# Eight-Pin Port Interrupt Detector

This block watches one port of eight general-purpose pins, which arrive already synchronized to the block clock. For each pin it can detect one of five trigger conditions: a high level, a low level, a rising edge, a falling edge, or any change.

A detected condition sets that pin's sticky status bit. Software acknowledges a status bit by writing a one to the matching bit of a clear register. A per-pin enable mask selects which status bits may raise the single registered port interrupt.

Configuration uses a small word-wide register bus with a registered read path. Masked-write aliases let software change the enable bits, the trigger types or the status bits of chosen pins without a read-modify-write cycle. The masked aliases sit at a parameterized upper offset.

Top module: `pin_irq_port`

## Requirements
- R1: After synchronous reset, status, enable and trigger-type contents are all zero, `irq_o` is low and `bus_rdata` reads zero.
- R2: The 24-bit trigger-type word gives pin i three fields: bit i is the polarity, bit i+8 selects edge rather than level, and bit i+16 selects both edges. The per-pin encodings are level high 0x000001, level low 0x000000, rising 0x000101, falling 0x000100 and any-change 0x010100, each shifted left by i.
- R3: An edge is found by comparing a pin with its value sampled one clock earlier. A change in the direction that was not selected sets nothing.
- R4: A status bit stays set once its condition has passed, until software clears it.
- R5: A write to offset 0x70 clears every status bit whose data bit is 1. Zero data bits leave status unchanged.
- R6: For a level-type pin, a clear write drops the status bit for one cycle. If the level is still active, the bit sets again on the following clock.
- R7: For an edge-type pin, an edge arriving in the same cycle as a clear of that bit wins, and the bit stays set.
- R8: `irq_o` is a register that goes high one clock after any pin has both its status and enable bits set, and it is low otherwise.
- R9: A write to 0x50 loads enable from data bits [7:0], and a write to 0x60 loads the type word from bits [23:0]. A write to 0x40 is ignored. Reads at 0x40, 0x50 and 0x60 (and at their aliases) return status, enable and type zero-extended, one clock after the address is presented.
- R10: A write to UPPER_OFS+0x50 updates enable only for pins whose bit in data [15:8] is set, taking the new value from data [7:0].
- R11: A write to UPPER_OFS+0x60 updates all three type fields, only for pins whose bit in data [31:24] is set, taking them from data [23:0].
- R12: A write to UPPER_OFS+0x40 forces the status of each pin selected in data [15:8] to its bit in data [7:0]. A simultaneous edge on that pin still sets the bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| pins_i | input | 8 | Synchronized pin levels |
| bus_we | input | 1 | Write strobe for the register bus |
| bus_addr | input | 12 | Register byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data for the address of the previous cycle |
| irq_o | output | 1 | Registered port interrupt |

## Verification
The bench programs all five trigger kinds on one port at once and drives pin transitions between level pairs. A detector that fires on the opposite edge, or that treats any-change as rising, would then leave the wrong status pattern. It issues a clear in the same cycle as a rising edge: a design that let the clear win would lose that event. It reads a level-type status twice right after clearing it: a design without the one-cycle drop, or one that never re-sets the bit, shows up there. The masked aliases are tested with data in unselected lanes that would corrupt other pins if the mask were ignored. A plain status write is checked to have no effect, and a clear with zero bits is checked to leave status untouched.

// File: rtl/pin_irq_pkg.sv
package pin_irq_pkg;

  localparam int unsigned OFS_STATUS = 32'h40;
  localparam int unsigned OFS_ENABLE = 32'h50;
  localparam int unsigned OFS_TYPE   = 32'h60;
  localparam int unsigned OFS_CLEAR  = 32'h70;

  typedef struct packed {
    logic any_chg;
    logic edge_sel;
    logic pol;
  } trig_t;

endpackage

// File: rtl/pin_irq_regs.sv
module pin_irq_regs
  import pin_irq_pkg::*;
#(
  parameter int NPINS     = 8,
  parameter int DW        = 32,
  parameter int ADDR_W    = 12,
  parameter int UPPER_OFS = 32'h80
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 we,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [DW-1:0]        wdata,
  input  logic [NPINS-1:0]     status_i,
  output logic [NPINS-1:0]     enable_o,
  output logic [3*NPINS-1:0]   type_o,
  output logic [NPINS-1:0]     clr_o,
  output logic [NPINS-1:0]     mset_o,
  output logic [NPINS-1:0]     mval_o,
  output logic [DW-1:0]        rdata_o
);

  localparam int TW = 3 * NPINS;

  localparam logic [ADDR_W-1:0] A_ST  = ADDR_W'(OFS_STATUS);
  localparam logic [ADDR_W-1:0] A_EN  = ADDR_W'(OFS_ENABLE);
  localparam logic [ADDR_W-1:0] A_TY  = ADDR_W'(OFS_TYPE);
  localparam logic [ADDR_W-1:0] A_CL  = ADDR_W'(OFS_CLEAR);
  localparam logic [ADDR_W-1:0] A_MST = ADDR_W'(UPPER_OFS + OFS_STATUS);
  localparam logic [ADDR_W-1:0] A_MEN = ADDR_W'(UPPER_OFS + OFS_ENABLE);
  localparam logic [ADDR_W-1:0] A_MTY = ADDR_W'(UPPER_OFS + OFS_TYPE);

  logic [NPINS-1:0] enable_q;
  logic [TW-1:0]    type_q;
  logic [DW-1:0]    rdata_q;
  logic [NPINS-1:0] en_sel;
  logic [TW-1:0]    ty_sel;
  logic [DW-1:0]    rd_next;

  assign en_sel = wdata[2*NPINS-1:NPINS];
  assign ty_sel = {3{wdata[4*NPINS-1:3*NPINS]}};

  always_comb begin
    rd_next = '0;
    if (addr == A_ST || addr == A_MST) rd_next = DW'(status_i);
    else if (addr == A_EN || addr == A_MEN) rd_next = DW'(enable_q);
    else if (addr == A_TY || addr == A_MTY) rd_next = DW'(type_q);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      enable_q <= '0;
      type_q   <= '0;
      rdata_q  <= '0;
    end else begin
      rdata_q <= rd_next;
      if (we && addr == A_EN) enable_q <= wdata[NPINS-1:0];
      if (we && addr == A_MEN)
        enable_q <= (enable_q & ~en_sel) | (wdata[NPINS-1:0] & en_sel);
      if (we && addr == A_TY) type_q <= wdata[TW-1:0];
      if (we && addr == A_MTY)
        type_q <= (type_q & ~ty_sel) | (wdata[TW-1:0] & ty_sel);
    end
  end

  assign clr_o    = (we && addr == A_CL) ? wdata[NPINS-1:0] : '0;
  assign mset_o   = (we && addr == A_MST) ? en_sel : '0;
  assign mval_o   = wdata[NPINS-1:0];
  assign enable_o = enable_q;
  assign type_o   = type_q;
  assign rdata_o  = rdata_q;

  // R10
  mask_en_chk: assert property (@(posedge clk) disable iff (rst)
    (we && addr == A_MEN) |=> (((enable_q ^ $past(enable_q)) & ~$past(en_sel)) == '0));

  // R11
  mask_type_chk: assert property (@(posedge clk) disable iff (rst)
    (we && addr == A_MTY) |=> (((type_q ^ $past(type_q)) & ~$past(ty_sel)) == '0));

endmodule

// File: rtl/pin_irq_detect.sv
module pin_irq_detect
  import pin_irq_pkg::*;
#(
  parameter int NPINS = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NPINS-1:0]   pin_i,
  input  logic [3*NPINS-1:0] type_i,
  output logic [NPINS-1:0]   event_o,
  output logic [NPINS-1:0]   edge_mode_o
);

  logic [NPINS-1:0] prev_q;

  // Tracks the pins even in reset so that no false edge follows reset release.
  always_ff @(posedge clk) prev_q <= pin_i;

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    trig_t cfg;
    logic  rise, fall;
    assign cfg  = '{any_chg: type_i[2*NPINS+i], edge_sel: type_i[NPINS+i], pol: type_i[i]};
    assign rise = pin_i[i] & ~prev_q[i];
    assign fall = ~pin_i[i] & prev_q[i];

    always_comb begin
      if (!cfg.edge_sel)   event_o[i] = (pin_i[i] == cfg.pol);
      else if (cfg.any_chg) event_o[i] = rise | fall;
      else if (cfg.pol)    event_o[i] = rise;
      else                 event_o[i] = fall;
    end
    assign edge_mode_o[i] = cfg.edge_sel;

    // R3
    edge_needs_change_chk: assert property (@(posedge clk) disable iff (rst)
      (edge_mode_o[i] && event_o[i] && !$past(rst)) |-> (pin_i[i] != $past(pin_i[i])));
  end

endmodule

// File: rtl/pin_irq_status.sv
module pin_irq_status #(
  parameter int NPINS = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NPINS-1:0] event_i,
  input  logic [NPINS-1:0] edge_mode_i,
  input  logic [NPINS-1:0] clr_i,
  input  logic [NPINS-1:0] mset_i,
  input  logic [NPINS-1:0] mval_i,
  input  logic [NPINS-1:0] enable_i,
  output logic [NPINS-1:0] status_o,
  output logic             irq_o
);

  logic [NPINS-1:0] status_q;
  logic [NPINS-1:0] status_d;
  logic             irq_q;

  for (genvar i = 0; i < NPINS; i++) begin : g_bit
    logic base;
    always_comb begin
      if (mset_i[i])     base = mval_i[i];
      else if (clr_i[i]) base = 1'b0;
      else               base = status_q[i];
      if (edge_mode_i[i])                base = base | event_i[i];
      else if (!(mset_i[i] || clr_i[i])) base = base | event_i[i];
      status_d[i] = base;
    end

    // R4
    sticky_chk: assert property (@(posedge clk) disable iff (rst)
      (status_q[i] && !clr_i[i] && !mset_i[i]) |=> status_q[i]);

    // R6
    level_clear_chk: assert property (@(posedge clk) disable iff (rst)
      (clr_i[i] && !mset_i[i] && !edge_mode_i[i]) |=> !status_q[i]);

    // R12
    mask_status_chk: assert property (@(posedge clk) disable iff (rst)
      (mset_i[i] && mval_i[i]) |=> status_q[i]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      status_q <= '0;
      irq_q    <= 1'b0;
    end else begin
      status_q <= status_d;
      irq_q    <= |(status_q & enable_i);
    end
  end

  assign status_o = status_q;
  assign irq_o    = irq_q;

endmodule

// File: rtl/pin_irq_port.sv
module pin_irq_port #(
  parameter int NPINS     = 8,
  parameter int DW        = 32,
  parameter int ADDR_W    = 12,
  parameter int UPPER_OFS = 32'h80
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NPINS-1:0]  pins_i,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  output logic              irq_o
);

  logic [NPINS-1:0]   status_w, enable_w, clr_w, mset_w, mval_w, event_w, edge_w;
  logic [3*NPINS-1:0] type_w;

  pin_irq_regs #(.NPINS(NPINS), .DW(DW), .ADDR_W(ADDR_W), .UPPER_OFS(UPPER_OFS)) u_regs (
    .clk(clk), .rst(rst), .we(bus_we), .addr(bus_addr), .wdata(bus_wdata),
    .status_i(status_w), .enable_o(enable_w), .type_o(type_w),
    .clr_o(clr_w), .mset_o(mset_w), .mval_o(mval_w), .rdata_o(bus_rdata)
  );

  pin_irq_detect #(.NPINS(NPINS)) u_detect (
    .clk(clk), .rst(rst), .pin_i(pins_i), .type_i(type_w),
    .event_o(event_w), .edge_mode_o(edge_w)
  );

  pin_irq_status #(.NPINS(NPINS)) u_status (
    .clk(clk), .rst(rst), .event_i(event_w), .edge_mode_i(edge_w),
    .clr_i(clr_w), .mset_i(mset_w), .mval_i(mval_w), .enable_i(enable_w),
    .status_o(status_w), .irq_o(irq_o)
  );

  // R7
  for (genvar i = 0; i < NPINS; i++) begin : g_chk
    edge_wins_chk: assert property (@(posedge clk) disable iff (rst)
      (edge_w[i] && event_w[i]) |=> status_w[i]);
  end

  // R8
  irq_follow_chk: assert property (@(posedge clk) disable iff (rst)
    (|(status_w & enable_w)) |=> irq_o);

  // R8
  irq_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    ((status_w & enable_w) == '0 && !$past(rst)) |=> !irq_o);

endmodule

// File: tb/pin_irq_port_tb_top.sv
`timescale 1ns/1ps
module pin_irq_port_tb_top;

  localparam logic [11:0] A_ST = 12'h040, A_EN = 12'h050, A_TY = 12'h060, A_CL = 12'h070;
  localparam logic [11:0] A_MST = 12'h0C0, A_MEN = 12'h0D0, A_MTY = 12'h0E0;
  // pin0 rise, pin1 fall, pin2 any, pin3 high, pin4 low, pin5 rise, pin6 fall, pin7 any
  localparam logic [31:0] MIX_TYPE = 32'h0084E729;
  // {pins_a, pins_b, enable, expected status, expected irq}
  localparam logic [39:0] VEC [0:5] = '{
    40'h00_FF_01_BD_01,
    40'hFF_00_01_DE_00,
    40'h55_AA_03_FC_00,
    40'h18_18_08_08_01,
    40'h21_42_EF_10_00,
    40'h81_00_80_90_01
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  pins = 8'hFF;
  logic        we = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;
  int          checks = 0;
  int          errors = 0;

  always #2 clk = ~clk;

  pin_irq_port dut_i (
    .clk(clk), .rst(rst), .pins_i(pins), .bus_we(we), .bus_addr(addr),
    .bus_wdata(wdata), .bus_rdata(rdata), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    addr = a;
    @(negedge clk);
    d = rdata;
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog actual hung expected done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 irq", {31'b0, irq}, 32'h0);
    rd(A_ST, v); chk("R1 status", v, 32'h0);
    rd(A_EN, v); chk("R1 enable", v, 32'h0);
    rd(A_TY, v); chk("R1 type", v, 32'h0);

    // R2 R3 R4 R8 vector table
    for (int k = 0; k < 6; k++) begin
      pins = VEC[k][39:32];
      wr(A_TY, MIX_TYPE);
      wr(A_EN, {24'h0, VEC[k][23:16]});
      repeat (3) @(negedge clk);
      wr(A_CL, 32'hFF);
      @(negedge clk);
      pins = VEC[k][31:24];
      repeat (3) @(negedge clk);
      rd(A_ST, v);
      chk("R2/R3/R4 status", v, {24'h0, VEC[k][15:8]});
      chk("R8 irq", {31'b0, irq}, {31'b0, VEC[k][0]});
    end

    // R9 readback and ignored status write
    wr(A_EN, 32'h0);
    wr(A_TY, 32'h0000FFFF);
    pins = 8'h00;
    repeat (3) @(negedge clk);
    wr(A_CL, 32'hFF);
    rd(A_TY, v); chk("R9 type readback", v, 32'h0000FFFF);
    wr(A_ST, 32'hFF);
    rd(A_ST, v); chk("R9 status write ignored", v, 32'h0);

    // R7 rising edge in the same cycle as its clear
    pins = 8'h01;
    wr(A_CL, 32'h01);
    rd(A_ST, v); chk("R7 edge beats clear", v, 32'h01);
    // R5 zero bits do nothing, one bits clear
    wr(A_CL, 32'h00);
    rd(A_ST, v); chk("R5 zero clear", v, 32'h01);
    wr(A_CL, 32'h01);
    rd(A_ST, v); chk("R5 one clear", v, 32'h00);

    // R12 masked status
    wr(A_MST, 32'h0505);
    rd(A_ST, v); chk("R12 masked set", v, 32'h05);
    wr(A_EN, 32'h04);
    @(negedge clk);
    chk("R8 irq from masked status", {31'b0, irq}, 32'h1);
    wr(A_MST, 32'h0100);
    rd(A_ST, v); chk("R12 masked clear", v, 32'h04);

    // R10 masked enable
    wr(A_EN, 32'h0F);
    wr(A_MEN, 32'h3010);
    rd(A_MEN, v); chk("R10 masked enable", v, 32'h1F);

    // R11 masked type, pin0 to falling
    wr(A_TY, MIX_TYPE);
    wr(A_MTY, 32'h01FEFFFE);
    rd(A_TY, v); chk("R11 masked type", v, 32'h0084E728);

    // R6 level clear drops one cycle then re-sets
    pins = 8'hFF;
    wr(A_TY, 32'h00000008);
    repeat (3) @(negedge clk);
    rd(A_ST, v); chk("R6 level before clear", v & 32'h08, 32'h08);
    wr(A_CL, 32'h08);
    rd(A_ST, v); chk("R6 dropped", v & 32'h08, 32'h00);
    rd(A_ST, v); chk("R6 re-set", v & 32'h08, 32'h08);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule